// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the byte-wide register file that a host processor uses to program a four-channel slave DMA controller. The host sees sixteen byte ports selected by a 4-bit offset, with separate read and write strobes. Each channel owns a 16-bit address and a 16-bit count. Each of these values holds a base copy and a current copy. Because every port is one byte wide, a 16-bit value moves as two successive accesses to the same port. A shared byte-pointer flip-flop tracks which half is next. The host can clear that pointer, and it toggles on every address or count access.

Next to the per-channel values sit a command byte, a mode field per channel, a mask bit per channel, a software request bit per channel, a status byte and a temporary byte. Mask, request and mode writes name their target channel in data bits 1:0. A separate transfer engine reads the configuration, the masks and the current address and count from the outputs. In return, it sends back new current values, a terminal-count event and the temporary byte. A terminal count on a channel with autoinitialize reloads that channel's current values from its base values.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all address and count copies, modes, the command byte, requests, status flags, the temporary byte and the byte pointer are zero, and all four mask bits are set.
- R2: A host write to an address or count port stores the byte in both the base and the current copy. Offset 0 of the pointer selects bits 7:0 and 1 selects bits 15:8. A read of that port returns the same byte lane of the current copy.
- R3: The byte pointer toggles after every read or write to offsets 0x0-0x7. Any write to offset 0xC clears it.
- R4: Channel n's address is at offset 2n and its count at offset 2n+1. A write there changes no other channel's values.
- R5: A write to offset 0xA selects channel data[1:0] and sets that channel's mask bit to data[2].
- R6: A write to offset 0xF loads data[3:0] as the mask bits of channels 3..0. A write to offset 0xE clears all mask bits.
- R7: A write to offset 0xB stores data[7:2] as the mode field of channel data[1:0]. The field is output as ch_mode[6n+5:6n]. Its bit 2 (written bit 4, value 0x10) is autoinitialize.
- R8: A write to offset 0x9 sets the request bit of channel data[1:0] to data[2]. A terminal count on a channel clears its request unless a host request write targets that channel in the same cycle.
- R9: A read of offset 0x8 returns {request[3:0], tc_flag[3:0]}. A terminal count sets that channel's flag. A status read clears all flags, but a flag set in the same cycle wins.
- R10: A write to offset 0xD clears the byte pointer, command, requests, status flags and temporary byte, and sets all mask bits. Address, count and mode values are kept.
- R11: An engine update (eng_upd) replaces the current address and count of channel eng_ch and leaves the base copies unchanged. A host write to the same register in the same cycle wins.
- R12: An engine update with eng_tc on an autoinitialize channel reloads the current copies from the base copies. Without autoinitialize it sets that channel's mask bit, unless the host writes a mask in the same cycle.
- R13: A write to offset 0x8 loads the command byte. eng_tmp_we loads the temporary byte, which is read at offset 0xD. All other read offsets return 0, and host_rdata is 0 when host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_offs | input | 4 | Host port offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| eng_upd | input | 1 | Engine current-value update |
| eng_ch | input | 2 | Channel of the engine update |
| eng_tc | input | 1 | Terminal count with the update |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_tmp_we | input | 1 | Temporary byte load |
| eng_tmp_data | input | 8 | Temporary byte value |
| cmd_word | output | 8 | Command byte |
| ch_mask | output | 4 | Per-channel mask bits |
| ch_mode | output | 24 | Per-channel mode fields, 6 bits each |
| ch_req | output | 4 | Per-channel software requests |
| ch_addr | output | 64 | Current addresses, 16 bits per channel |
| ch_count | output | 64 | Current counts, 16 bits per channel |

## Verification
A byte pointer that is out of step shows at the next 16-bit read, which returns the wrong half of the value. It also shows one cycle after the next write, when ch_addr or ch_count changes in the wrong lane. A stale status flag or request appears at the next status read, and a wrong mask or mode appears on ch_mask or ch_mode one cycle after the event that caused it. The bench therefore compares every output after every cycle against a model, so a fault is reported within one cycle of the first observable effect. Simultaneous host and engine events are exercised to expose priority errors.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_REQ    = 4'h9;
  localparam logic [3:0] OFS_SMASK  = 4'hA;
  localparam logic [3:0] OFS_MODE   = 4'hB;
  localparam logic [3:0] OFS_PTRCLR = 4'hC;
  localparam logic [3:0] OFS_MCLR   = 4'hD;
  localparam logic [3:0] OFS_UNMASK = 4'hE;
  localparam logic [3:0] OFS_AMASK  = 4'hF;

  // bit of the stored mode field that enables autoinitialize
  localparam int MODE_AI_BIT = 2;

  // replace one byte lane of a 16-bit value
  function automatic logic [15:0] put_byte(input logic [15:0] v, input logic hi,
                                           input logic [7:0] b);
    logic [15:0] r;
    r = v;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  function automatic logic [7:0] get_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction
endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic ptr_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_hi <= 1'b0;
    else if (clr)  ptr_hi <= 1'b0;
    else if (step) ptr_hi <= ~ptr_hi;
  end

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ptr_hi); // R3
  AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (ptr_hi != $past(ptr_hi))); // R3
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(ptr_hi)); // R3
endmodule

// File: rtl/dmac_pair.sv
module dmac_pair #(
  parameter int VW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          hi,
  input  logic [DW-1:0] wdata,
  input  logic          eng_we,
  input  logic [VW-1:0] eng_val,
  input  logic          reload,
  output logic [VW-1:0] cur,
  output logic [DW-1:0] rd_byte
);
  import dmac_pkg::*;

  logic [VW-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else if (host_we) begin
      base <= put_byte(base, hi, wdata);
      cur  <= put_byte(cur, hi, wdata);
    end else if (reload) begin
      cur <= base;
    end else if (eng_we) begin
      cur <= eng_val;
    end
  end

  assign rd_byte = get_byte(cur, hi);

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> $stable(base)); // R11
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !host_we) |=> (cur == $past(base))); // R12
  AST_ENG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !reload && !host_we) |=> (cur == $past(eng_val))); // R11
  AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (get_byte(cur, $past(hi)) == $past(wdata)
                 && get_byte(base, $past(hi)) == $past(wdata))); // R2
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mclr,
  input  logic                       wr_cmd,
  input  logic                       wr_req,
  input  logic                       wr_smask,
  input  logic                       wr_mode,
  input  logic                       wr_unmask,
  input  logic                       wr_amask,
  input  logic                       rd_stat,
  input  logic [DW-1:0]              wdata,
  input  logic [NCH-1:0]             tc_ev,
  input  logic                       temp_we,
  input  logic [DW-1:0]              temp_d,
  output logic [NCH-1:0]             mask,
  output logic [NCH*(DW-$clog2(NCH))-1:0] mode_flat,
  output logic [NCH-1:0]             autoinit,
  output logic [NCH-1:0]             req,
  output logic [NCH-1:0]             tcf,
  output logic [DW-1:0]              cmd,
  output logic [DW-1:0]              temp
);
  import dmac_pkg::*;
  localparam int CHW = $clog2(NCH);
  localparam int MW  = DW - CHW;

  logic [CHW-1:0] sel_ch;
  logic           set_bit;
  assign sel_ch  = wdata[CHW-1:0];
  assign set_bit = wdata[CHW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      temp <= '0;
    end else if (mclr) begin
      cmd  <= '0;
      temp <= '0;
    end else begin
      if (wr_cmd)  cmd  <= wdata;
      if (temp_we) temp <= temp_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit;
    logic [MW-1:0] mode_q;
    assign hit = (sel_ch == CHW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode_q <= '0;
      else if (wr_mode && hit)   mode_q <= wdata[DW-1:CHW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask[i] <= 1'b1;
      else if (mclr)                     mask[i] <= 1'b1;
      else if (wr_amask)                 mask[i] <= wdata[i];
      else if (wr_unmask)                mask[i] <= 1'b0;
      else if (wr_smask && hit)          mask[i] <= set_bit;
      else if (tc_ev[i] && !autoinit[i]) mask[i] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              req[i] <= 1'b0;
      else if (mclr)           req[i] <= 1'b0;
      else if (wr_req && hit)  req[i] <= set_bit;
      else if (tc_ev[i])       req[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tcf[i] <= 1'b0;
      else if (mclr)     tcf[i] <= 1'b0;
      else if (tc_ev[i]) tcf[i] <= 1'b1;
      else if (rd_stat)  tcf[i] <= 1'b0;
    end

    assign mode_flat[i*MW +: MW] = mode_q;
    assign autoinit[i]           = mode_q[MODE_AI_BIT];

    AST_TC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ev[i] && !mclr) |=> tcf[i]); // R9
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !tc_ev[i]) |=> !tcf[i]); // R9
    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ev[i] && !autoinit[i] && !wr_amask && !wr_unmask && !(wr_smask && hit))
        |=> mask[i]); // R12
    AST_TC_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ev[i] && !(wr_req && hit)) |=> !req[i]); // R8
  end

  AST_MCLR_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask == {NCH{1'b1}} && req == '0 && tcf == '0)); // R10
  AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmask && !mclr && !wr_amask) |=> (mask == '0)); // R6
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int VW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           host_offs,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  input  logic                 eng_upd,
  input  logic [$clog2(NCH)-1:0] eng_ch,
  input  logic                 eng_tc,
  input  logic [VW-1:0]        eng_addr,
  input  logic [VW-1:0]        eng_cnt,
  input  logic                 eng_tmp_we,
  input  logic [DW-1:0]        eng_tmp_data,
  output logic [DW-1:0]        cmd_word,
  output logic [NCH-1:0]       ch_mask,
  output logic [NCH*(DW-$clog2(NCH))-1:0] ch_mode,
  output logic [NCH-1:0]       ch_req,
  output logic [NCH*VW-1:0]    ch_addr,
  output logic [NCH*VW-1:0]    ch_count
);
  import dmac_pkg::*;
  localparam int CHW = $clog2(NCH);

  // decoded host events, named for the checks
  logic           ev_pair;
  logic           ev_ptr_clr;
  logic           ev_mclr;
  logic           ev_rd_stat;
  logic [CHW-1:0] pair_ch;
  logic           pair_is_cnt;
  logic           ptr_hi;
  logic [NCH-1:0] tc_ev;
  logic [NCH-1:0] eng_hit;
  logic [NCH-1:0] ai;
  logic [NCH-1:0] tcf;
  logic [DW-1:0]  temp;
  logic [DW-1:0]  addr_byte [NCH];
  logic [DW-1:0]  cnt_byte  [NCH];

  assign ev_pair     = (host_wr || host_rd) && !host_offs[3];
  assign ev_mclr     = host_wr && (host_offs == OFS_MCLR);
  assign ev_ptr_clr  = ev_mclr || (host_wr && (host_offs == OFS_PTRCLR));
  assign ev_rd_stat  = host_rd && (host_offs == OFS_CMD);
  assign pair_ch     = host_offs[CHW:1];
  assign pair_is_cnt = host_offs[0];

  dmac_byteptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ev_ptr_clr), .step(ev_pair), .ptr_hi(ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic wr_a, wr_c, rel;
    assign eng_hit[i] = eng_upd && (eng_ch == CHW'(i));
    assign tc_ev[i]   = eng_hit[i] && eng_tc;
    assign rel        = tc_ev[i] && ai[i];
    assign wr_a = host_wr && !host_offs[3] && (pair_ch == CHW'(i)) && !pair_is_cnt;
    assign wr_c = host_wr && !host_offs[3] && (pair_ch == CHW'(i)) && pair_is_cnt;

    dmac_pair #(.VW(VW), .DW(DW)) u_addr (
      .clk(clk), .rst_n(rst_n), .host_we(wr_a), .hi(ptr_hi), .wdata(host_wdata),
      .eng_we(eng_hit[i]), .eng_val(eng_addr), .reload(rel),
      .cur(ch_addr[i*VW +: VW]), .rd_byte(addr_byte[i])
    );
    dmac_pair #(.VW(VW), .DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .host_we(wr_c), .hi(ptr_hi), .wdata(host_wdata),
      .eng_we(eng_hit[i]), .eng_val(eng_cnt), .reload(rel),
      .cur(ch_count[i*VW +: VW]), .rd_byte(cnt_byte[i])
    );
  end

  dmac_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mclr(ev_mclr),
    .wr_cmd(host_wr && host_offs == OFS_CMD),
    .wr_req(host_wr && host_offs == OFS_REQ),
    .wr_smask(host_wr && host_offs == OFS_SMASK),
    .wr_mode(host_wr && host_offs == OFS_MODE),
    .wr_unmask(host_wr && host_offs == OFS_UNMASK),
    .wr_amask(host_wr && host_offs == OFS_AMASK),
    .rd_stat(ev_rd_stat), .wdata(host_wdata), .tc_ev(tc_ev),
    .temp_we(eng_tmp_we), .temp_d(eng_tmp_data),
    .mask(ch_mask), .mode_flat(ch_mode), .autoinit(ai), .req(ch_req),
    .tcf(tcf), .cmd(cmd_word), .temp(temp)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (!host_offs[3])
        host_rdata = pair_is_cnt ? cnt_byte[pair_ch] : addr_byte[pair_ch];
      else if (host_offs == OFS_CMD)
        host_rdata = {ch_req, tcf};
      else if (host_offs == OFS_MCLR)
        host_rdata = temp;
    end
  end

  AST_MCLR_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mclr |=> (cmd_word == '0)); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> (host_rdata == '0)); // R13
  AST_ONE_ENGINE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_hit)); // R11
endmodule

// File: tb/dmac_regfile_tb_top.sv
module dmac_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_offs = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        eng_upd = 1'b0, eng_tc = 1'b0, eng_tmp_we = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [15:0] eng_addr = '0, eng_cnt = '0;
  logic [7:0]  eng_tmp_data = '0;
  logic [7:0]  cmd_word;
  logic [3:0]  ch_mask, ch_req;
  logic [23:0] ch_mode;
  logic [63:0] ch_addr, ch_count;

  always #2.5 clk = ~clk;

  dmac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .host_offs(host_offs), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_upd(eng_upd), .eng_ch(eng_ch), .eng_tc(eng_tc), .eng_addr(eng_addr),
    .eng_cnt(eng_cnt), .eng_tmp_we(eng_tmp_we), .eng_tmp_data(eng_tmp_data),
    .cmd_word(cmd_word), .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_req(ch_req),
    .ch_addr(ch_addr), .ch_count(ch_count)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req, m_tcf;
  logic [7:0]  m_cmd, m_tmp;
  logic        m_ptr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_set(input logic [15:0] v, input logic hi,
                                           input logic [7:0] b);
    return hi ? {b, v[7:0]} : {v[15:8], b};
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] o);
    logic [15:0] v;
    if (o < 4'd8) begin
      v = o[0] ? m_cc[o[2:1]] : m_ca[o[2:1]];
      return m_ptr ? v[15:8] : v[7:0];
    end
    if (o == 4'd8)  return {m_req, m_tcf};
    if (o == 4'hD)  return m_tmp;
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_req = 0; m_tcf = 0; m_cmd = 0; m_tmp = 0; m_ptr = 0;
  endtask

  task automatic model_step(input bit w, input bit r, input logic [3:0] o,
                            input logic [7:0] d, input bit eu, input logic [1:0] ec,
                            input bit tc, input logic [15:0] ea, input logic [15:0] en,
                            input bit tw, input logic [7:0] td);
    bit mclr;
    bit ai [4];
    logic [3:0] nmask, nreq, ntcf;
    mclr = w && o == 4'hD;
    for (int i = 0; i < 4; i++) ai[i] = m_mode[i][2];
    for (int i = 0; i < 4; i++) begin
      bit hit_e, tce;
      hit_e = eu && ec == 2'(i);
      tce   = hit_e && tc;
      if (w && o == 4'(2*i)) begin
        m_ba[i] = lane_set(m_ba[i], m_ptr, d); m_ca[i] = lane_set(m_ca[i], m_ptr, d);
      end else if (tce && ai[i]) m_ca[i] = m_ba[i];
      else if (hit_e) m_ca[i] = ea;
      if (w && o == 4'(2*i+1)) begin
        m_bc[i] = lane_set(m_bc[i], m_ptr, d); m_cc[i] = lane_set(m_cc[i], m_ptr, d);
      end else if (tce && ai[i]) m_cc[i] = m_bc[i];
      else if (hit_e) m_cc[i] = en;
      nmask[i] = m_mask[i];
      if (mclr) nmask[i] = 1;
      else if (w && o == 4'hF) nmask[i] = d[i];
      else if (w && o == 4'hE) nmask[i] = 0;
      else if (w && o == 4'hA && d[1:0] == 2'(i)) nmask[i] = d[2];
      else if (tce && !ai[i]) nmask[i] = 1;
      nreq[i] = m_req[i];
      if (mclr) nreq[i] = 0;
      else if (w && o == 4'h9 && d[1:0] == 2'(i)) nreq[i] = d[2];
      else if (tce) nreq[i] = 0;
      ntcf[i] = m_tcf[i];
      if (mclr) ntcf[i] = 0;
      else if (tce) ntcf[i] = 1;
      else if (r && o == 4'h8) ntcf[i] = 0;
    end
    m_mask = nmask; m_req = nreq; m_tcf = ntcf;
    if (w && o == 4'hB) m_mode[d[1:0]] = d[7:2];
    if (mclr) begin m_cmd = 0; m_tmp = 0; end
    else begin
      if (w && o == 4'h8) m_cmd = d;
      if (tw) m_tmp = td;
    end
    if (mclr || (w && o == 4'hC)) m_ptr = 0;
    else if ((w || r) && o < 4'd8) m_ptr = ~m_ptr;
  endtask

  task automatic check_outputs();
    chk(ch_mask == m_mask, "R5 R6 R12 mask", 64'(ch_mask), 64'(m_mask));
    chk(ch_req == m_req, "R8 request", 64'(ch_req), 64'(m_req));
    chk(cmd_word == m_cmd, "R13 command", 64'(cmd_word), 64'(m_cmd));
    for (int i = 0; i < 4; i++) begin
      chk(ch_mode[i*6 +: 6] == m_mode[i], "R7 mode", 64'(ch_mode[i*6 +: 6]), 64'(m_mode[i]));
      chk(ch_addr[i*16 +: 16] == m_ca[i], "R11 R2 current address",
          64'(ch_addr[i*16 +: 16]), 64'(m_ca[i]));
      chk(ch_count[i*16 +: 16] == m_cc[i], "R11 R2 current count",
          64'(ch_count[i*16 +: 16]), 64'(m_cc[i]));
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [3:0] o, input logic [7:0] d,
                     input bit eu, input logic [1:0] ec, input bit tc,
                     input logic [15:0] ea, input logic [15:0] en,
                     input bit tw, input logic [7:0] td);
    logic [7:0] e;
    @(negedge clk);
    host_wr = w; host_rd = r; host_offs = o; host_wdata = d;
    eng_upd = eu; eng_ch = ec; eng_tc = tc; eng_addr = ea; eng_cnt = en;
    eng_tmp_we = tw; eng_tmp_data = td;
    #1;
    e = r ? exp_read(o) : 8'h00;
    if (o == 4'h8)      chk(host_rdata == e, "R9 status read", 64'(host_rdata), 64'(e));
    else if (o < 4'd8)  chk(host_rdata == e, "R2 R3 R4 pair read", 64'(host_rdata), 64'(e));
    else                chk(host_rdata == e, "R13 other read", 64'(host_rdata), 64'(e));
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; eng_upd = 0; eng_tc = 0; eng_tmp_we = 0;
    model_step(w, r, o, d, eu, ec, tc, ea, en, tw, td);
    check_outputs();
  endtask

  task automatic hw(input logic [3:0] o, input logic [7:0] d);
    cyc(1, 0, o, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic hr(input logic [3:0] o);
    cyc(0, 1, o, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic eng(input logic [1:0] c, input bit tc, input logic [15:0] a,
                     input logic [15:0] n);
    cyc(0, 0, 4'h0, 0, 1, c, tc, a, n, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk(ch_mask == 4'hF, "R1 mask reset", 64'(ch_mask), 64'hF);
    chk(ch_addr == '0 && ch_count == '0, "R1 values reset", ch_addr, 64'h0);
    check_outputs();
    hr(4'h8);
    // R2 R4: channel 2 address 0x1234, count 0xBEEF
    hw(4'h4, 8'h34); hw(4'h4, 8'h12);
    chk(ch_addr[47:32] == 16'h1234, "R2 address loaded", 64'(ch_addr[47:32]), 64'h1234);
    chk(ch_addr[31:0] == '0, "R4 other channels", 64'(ch_addr[31:0]), 64'h0);
    hw(4'h5, 8'hEF); hw(4'h5, 8'hBE);
    hr(4'h4); hr(4'h4); hr(4'h5); hr(4'h5);
    // R3: pointer clear in the middle of a pair
    hw(4'h0, 8'hAA); hw(4'hC, 8'h00); hw(4'h0, 8'h55);
    chk(ch_addr[15:0] == 16'h0055, "R3 pointer clear", 64'(ch_addr[15:0]), 64'h0055);
    hw(4'h0, 8'h66); hr(4'h0); hr(4'h1);
    // R5 R6 masks
    hw(4'hE, 0); hw(4'hA, 8'h06); hw(4'hA, 8'h02); hw(4'hA, 8'h07); hw(4'hF, 8'h05);
    chk(ch_mask == 4'h5, "R6 all-mask write", 64'(ch_mask), 64'h5);
    // R7 modes: channel 1 peripheral-to-memory with autoinit, channel 3 cascade
    hw(4'hB, 8'h44 | 8'h10 | 8'h01); hw(4'hB, 8'hC3); hw(4'hB, 8'h48 | 8'h02);
    chk(ch_mode[11:6] == 6'h15, "R7 mode field", 64'(ch_mode[11:6]), 64'h15);
    // R8 requests and R9 status
    hw(4'h9, 8'h05); hw(4'h9, 8'h06); hw(4'h9, 8'h02);
    hr(4'h8);
    // R11 engine update, R12 terminal count both ways
    eng(2'd2, 0, 16'h2000, 16'h0010);
    eng(2'd2, 1, 16'h2010, 16'h0000);
    chk(ch_mask[2] == 1'b1, "R12 tc masks", 64'(ch_mask[2]), 64'h1);
    hw(4'h2, 8'h00); hw(4'h2, 8'h40); eng(2'd1, 0, 16'h4321, 16'h0);
    eng(2'd1, 1, 16'h5555, 16'h5555);
    chk(ch_addr[31:16] == 16'h4000, "R12 autoinit reload", 64'(ch_addr[31:16]), 64'h4000);
    hr(4'h8); hr(4'h8);
    // R9 flag set wins over same-cycle status read
    cyc(0, 1, 4'h8, 0, 1, 2'd0, 1, 16'h1, 16'h1, 0, 0); hr(4'h8);
    // R11 host write wins over same-cycle engine update
    cyc(1, 0, 4'h6, 8'h77, 1, 2'd3, 0, 16'hFFFF, 16'hFFFF, 0, 0);
    // R13 command and temporary
    hw(4'h8, 8'h9C); cyc(0, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 8'h3E); hr(4'hD); hr(4'hB);
    // R10 master clear
    hw(4'h9, 8'h04); hw(4'h0, 8'h11); hw(4'hD, 8'h00);
    chk(ch_mask == 4'hF && ch_req == 0, "R10 master clear", 64'({ch_mask, ch_req}), 64'hF0);
    hr(4'hD); hr(4'h0);
    // random mix
    for (int n = 0; n < 6000; n++) begin
      int k;
      bit w, r, eu, tc, tw;
      logic [3:0] o;
      k = $urandom % 10;
      o = 4'($urandom);
      if (o == 4'hD && ($urandom % 4) != 0) o = 4'h3;
      w = (k < 4); r = (k >= 4 && k < 7);
      eu = ($urandom % 3) == 0; tc = ($urandom % 3) == 0; tw = ($urandom % 8) == 0;
      cyc(w, r, o, 8'($urandom), eu, 2'($urandom), tc, 16'($urandom), 16'($urandom),
          tw, 8'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule